// File: doc/BRIEF.md
# Circular Reorder Buffer with Rename Table

This block tracks instructions from decode to retirement. Each accepted allocation takes the next slot of a circular buffer, and the slot index becomes the instruction's tag. Functional units report results, with an optional exception cause, against that tag in any order. The oldest slot is retired to the register file only after it has completed, so architectural state changes strictly in program order.

A rename table holds one tag and one valid bit for each architectural register. The valid bit means the register's newest value is still owned by an in-flight slot. Decode looks up its two sources there: it gets the producing tag and a flag that says whether the operand can already be read. The register file holds only retired state.

When the oldest slot retires with an exception, or when the external flush input is raised, every in-flight slot is discarded. The free pointer is moved back onto the retire pointer and all rename valid bits are cleared in the same edge.

Top module: `rob_rename_top`

## Requirements
- R1: After reset the buffer is empty, `empty`=1, `full`=0, `alloc_ready`=1, `cm_valid`=0, `exc_valid`=0, and both source lookups report ready.
- R2: Tags are slot indices 0..DEPTH-1. They are handed out in circular order starting at 0. `alloc_tag` shows the tag that the current request takes, and a request is accepted at the edge when `alloc_valid` and `alloc_ready` are both 1.
- R3: After DEPTH accepted allocations with no retirement, `full`=1 and `alloc_ready`=0. A request made while full changes no slot and takes no tag.
- R4: A completion (`cmp_valid`=1) stores data, exception flag and cause into its slot in any order. A completion naming a slot that is not in use is ignored.
- R5: Only the oldest slot retires, and only once it has completed. Retirement happens one slot per cycle in program order, with `cm_valid`=1 and `cm_tag`, `cm_dst`, `cm_data` from that slot. It is shown in the cycle after the edge that recorded the completion.
- R6: A source lookup of a register with an in-flight producer returns that producer's newest tag. Its ready flag is 0 until that producer has completed. A register without an in-flight producer reads as ready.
- R7: On retirement the rename valid bit of the destination is cleared only if the stored tag equals the retiring tag. A younger mapping of the same register stays pending.
- R8: When the oldest completed slot carries an exception (`cmp_exc`=1 at completion), `exc_valid`=1 with `exc_tag` and `exc_cause`, `cm_valid`=0 and `alloc_ready`=0. After the next edge the buffer is empty, every rename valid bit is clear, and the next tag equals the excepting slot's index.
- R9: While `flush`=1, no retirement or exception is reported. After that edge the buffer is empty with the retire pointer unchanged, and all rename valid bits are clear.
- R10: The read port shows for slot `rd_tag` its in-use and completed flags, operation, and source tags with ready flags. A source ready flag is set at allocation if its producer had already completed or completes in that cycle. Otherwise it is set by the producer's completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_op | input | OP_W | Operation of the new instruction |
| alloc_dst | input | REG_W | Destination register |
| alloc_src1 | input | REG_W | First source register |
| alloc_src2 | input | REG_W | Second source register |
| alloc_ready | output | 1 | A request is accepted this cycle |
| alloc_tag | output | TAG_W | Tag the request takes |
| src1_tag | output | TAG_W | Producer tag of first source |
| src1_rdy | output | 1 | First source operand available |
| src2_tag | output | TAG_W | Producer tag of second source |
| src2_rdy | output | 1 | Second source operand available |
| cmp_valid | input | 1 | A functional unit reports a result |
| cmp_tag | input | TAG_W | Slot of the result |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Result raised an exception |
| cmp_cause | input | CAUSE_W | Exception cause |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_tag | output | TAG_W | Retiring slot |
| cm_dst | output | REG_W | Register file write address |
| cm_data | output | DATA_W | Register file write data |
| exc_valid | output | 1 | Oldest slot is taken as an exception |
| exc_tag | output | TAG_W | Excepting slot |
| exc_cause | output | CAUSE_W | Exception cause |
| flush | input | 1 | Discard all in-flight slots |
| empty | output | 1 | No slot in use |
| full | output | 1 | All slots in use |
| rd_tag | input | TAG_W | Slot to inspect |
| rd_use | output | 1 | Inspected slot in use |
| rd_exec | output | 1 | Inspected slot completed |
| rd_op | output | OP_W | Inspected slot operation |
| rd_src1_tag | output | TAG_W | Inspected first source tag |
| rd_src1_rdy | output | 1 | Inspected first source ready |
| rd_src2_tag | output | TAG_W | Inspected second source tag |
| rd_src2_rdy | output | 1 | Inspected second source ready |

## Verification
The tag offered and both source lookups depend combinationally on current state and inputs, so they are read in the same cycle the request is driven. A completion is visible on the read port and in the lookup ready flags one edge after it is driven. The retirement it unblocks appears on `cm_valid` in that same following cycle, and later completed slots follow one per cycle. An exception or flush is seen combinationally in its own cycle, and the emptied buffer and cleared table are checked after one more edge. The bench drives inputs and samples outputs a few time units after each rising edge. It derives every expected tag, data value and retirement order arithmetically from a bench-side slot counter, and it sweeps burst lengths 1 to DEPTH with reverse-order completion across several wraps.

// File: rtl/rob_pkg.sv
// Shared types of the reorder buffer.
package rob_pkg;
    // What the oldest slot does in the current cycle.
    typedef enum logic [1:0] {
        HEAD_WAIT   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_TRAP   = 2'd2
    } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
// Free and retire pointers of the circular buffer.
// Each pointer carries one extra wrap bit so full and empty differ.
// Assumes DEPTH is a power of two; flush moves the free pointer onto
// the retire pointer.
module rob_ptrs #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic                     flush,
    output logic [$clog2(DEPTH)-1:0] head_idx,
    output logic [$clog2(DEPTH)-1:0] tail_idx,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;

    // Advance or rewind the two pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else if (flush) begin
            tail <= head;
        end else begin
            if (push) tail <= tail + PTR_W'(1);
            if (pop)  head <= head + PTR_W'(1);
        end
    end

    // Derive occupancy and the full/empty flags.
    always_comb begin
        head_idx = head[IDX_W-1:0];
        tail_idx = tail[IDX_W-1:0];
        count    = tail - head;
        empty    = (tail == head);
        full     = (tail[IDX_W] != head[IDX_W]) && (tail_idx == head_idx);
    end

    // R3
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R5
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |=> (head == $past(head) + PTR_W'(1)));
endmodule

// File: rtl/rob_rename.sv
// Rename table: one tag and a valid bit per architectural register.
// Set on allocation and cleared on retirement only when the stored tag
// matches. All valid bits clear on flush. Lookups read the state before
// this cycle's update. Assumes NREG is a power of two.
module rob_rename #(
    parameter int NREG  = 8,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     set_en,
    input  logic [$clog2(NREG)-1:0]  set_reg,
    input  logic [$clog2(DEPTH)-1:0] set_tag,
    input  logic                     clr_en,
    input  logic [$clog2(NREG)-1:0]  clr_reg,
    input  logic [$clog2(DEPTH)-1:0] clr_tag,
    input  logic [$clog2(NREG)-1:0]  q1_reg,
    input  logic [$clog2(NREG)-1:0]  q2_reg,
    output logic [$clog2(DEPTH)-1:0] q1_tag,
    output logic                     q1_hit,
    output logic [$clog2(DEPTH)-1:0] q2_tag,
    output logic                     q2_hit
);
    localparam int REG_W = $clog2(NREG);
    localparam int TAG_W = $clog2(DEPTH);

    logic [TAG_W-1:0] map_tag [NREG];
    logic [NREG-1:0]  map_vld;

    for (genvar g = 0; g < NREG; g++) begin : reg_map
        // Keep the newest in-flight owner of register g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_vld[g] <= 1'b0;
                map_tag[g] <= '0;
            end else if (flush) begin
                map_vld[g] <= 1'b0;
            end else if (set_en && set_reg == REG_W'(g)) begin
                map_vld[g] <= 1'b1;
                map_tag[g] <= set_tag;
            end else if (clr_en && clr_reg == REG_W'(g) && map_tag[g] == clr_tag) begin
                map_vld[g] <= 1'b0;
            end
        end
    end

    // Look up both sources.
    always_comb begin
        q1_tag = map_tag[q1_reg];
        q1_hit = map_vld[q1_reg];
        q2_tag = map_tag[q2_reg];
        q2_hit = map_vld[q2_reg];
    end

    // R8
    clear_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (map_vld == '0));

    // R6
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !flush) |=> (map_vld[$past(set_reg)] && map_tag[$past(set_reg)] == $past(set_tag)));
endmodule

// File: rtl/rob_entries.sv
// Slot storage of the reorder buffer. Each slot keeps an in-use bit,
// a completed flag, the operation, two source tags with ready flags,
// the destination, the result and an exception flag with cause.
// Source ready flags are set when the producing slot completes.
// Assumes DEPTH is a power of two and at most one write per slot per
// cycle from the caller.
module rob_entries #(
    parameter int DEPTH   = 8,
    parameter int NREG    = 8,
    parameter int DATA_W  = 32,
    parameter int OP_W    = 6,
    parameter int CAUSE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [OP_W-1:0]          wr_op,
    input  logic [$clog2(NREG)-1:0]  wr_dst,
    input  logic [$clog2(DEPTH)-1:0] wr_s1_tag,
    input  logic                     wr_s1_rdy,
    input  logic [$clog2(DEPTH)-1:0] wr_s2_tag,
    input  logic                     wr_s2_rdy,
    input  logic                     cmp_valid,
    input  logic [$clog2(DEPTH)-1:0] cmp_tag,
    input  logic [DATA_W-1:0]        cmp_data,
    input  logic                     cmp_exc,
    input  logic [CAUSE_W-1:0]       cmp_cause,
    input  logic                     ret_en,
    input  logic [$clog2(DEPTH)-1:0] ret_idx,
    output logic [DEPTH-1:0]         use_vec,
    output logic [DEPTH-1:0]         exec_vec,
    input  logic [$clog2(DEPTH)-1:0] hd_idx,
    output logic                     hd_exc,
    output logic [CAUSE_W-1:0]       hd_cause,
    output logic [$clog2(NREG)-1:0]  hd_dst,
    output logic [DATA_W-1:0]        hd_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [OP_W-1:0]          rd_op,
    output logic [$clog2(DEPTH)-1:0] rd_s1_tag,
    output logic                     rd_s1_rdy,
    output logic [$clog2(DEPTH)-1:0] rd_s2_tag,
    output logic                     rd_s2_rdy
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int REG_W = $clog2(NREG);

    typedef struct packed {
        logic               live;
        logic               done;
        logic [OP_W-1:0]    op;
        logic [TAG_W-1:0]   s1_tag;
        logic               s1_rdy;
        logic [TAG_W-1:0]   s2_tag;
        logic               s2_rdy;
        logic [REG_W-1:0]   dst;
        logic [DATA_W-1:0]  data;
        logic               excf;
        logic [CAUSE_W-1:0] cause;
    } slot_t;

    slot_t view [DEPTH];
    logic  cmp_hit;

    // A completion counts only when it names a slot in use.
    always_comb cmp_hit = cmp_valid && use_vec[cmp_tag];

    for (genvar g = 0; g < DEPTH; g++) begin : slot
        slot_t e;

        // Update slot g on allocation, completion, wakeup and retirement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e <= '0;
            end else if (clr_all) begin
                e.live <= 1'b0;
                e.done <= 1'b0;
            end else if (wr_en && wr_idx == TAG_W'(g)) begin
                e.live   <= 1'b1;
                e.done   <= 1'b0;
                e.op     <= wr_op;
                e.s1_tag <= wr_s1_tag;
                e.s1_rdy <= wr_s1_rdy;
                e.s2_tag <= wr_s2_tag;
                e.s2_rdy <= wr_s2_rdy;
                e.dst    <= wr_dst;
                e.data   <= '0;
                e.excf   <= 1'b0;
                e.cause  <= '0;
            end else begin
                if (ret_en && ret_idx == TAG_W'(g)) begin
                    e.live <= 1'b0;
                    e.done <= 1'b0;
                end else if (cmp_hit && cmp_tag == TAG_W'(g)) begin
                    e.done  <= 1'b1;
                    e.data  <= cmp_data;
                    e.excf  <= cmp_exc;
                    e.cause <= cmp_cause;
                end
                if (e.live && cmp_hit && e.s1_tag == cmp_tag) e.s1_rdy <= 1'b1;
                if (e.live && cmp_hit && e.s2_tag == cmp_tag) e.s2_rdy <= 1'b1;
            end
        end

        assign view[g]     = e;
        assign use_vec[g]  = e.live;
        assign exec_vec[g] = e.done;
    end

    // Present the oldest slot and the inspected slot.
    always_comb begin
        hd_exc    = view[hd_idx].excf;
        hd_cause  = view[hd_idx].cause;
        hd_dst    = view[hd_idx].dst;
        hd_data   = view[hd_idx].data;
        rd_op     = view[rd_idx].op;
        rd_s1_tag = view[rd_idx].s1_tag;
        rd_s1_rdy = view[rd_idx].s1_rdy;
        rd_s2_tag = view[rd_idx].s2_tag;
        rd_s2_rdy = view[rd_idx].s2_rdy;
    end

    // R4
    stray_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !use_vec[cmp_tag] && !clr_all && !(wr_en && wr_idx == cmp_tag))
        |=> !exec_vec[$past(cmp_tag)]);

    // R4
    cmp_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && !clr_all && !(ret_en && ret_idx == cmp_tag))
        |=> exec_vec[$past(cmp_tag)]);
endmodule

// File: rtl/rob_rename_top.sv
// Reorder buffer with rename table. Decode allocates slots in order,
// functional units complete them in any order, the oldest completed
// slot retires each cycle, and an exception at the oldest slot or the
// flush input discards everything in flight. Assumes DEPTH and NREG
// are powers of two and units only complete tags they were issued.
module rob_rename_top
    import rob_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NREG    = 8,
    parameter int DATA_W  = 32,
    parameter int OP_W    = 6,
    parameter int CAUSE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [OP_W-1:0]          alloc_op,
    input  logic [$clog2(NREG)-1:0]  alloc_dst,
    input  logic [$clog2(NREG)-1:0]  alloc_src1,
    input  logic [$clog2(NREG)-1:0]  alloc_src2,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_tag,
    output logic [$clog2(DEPTH)-1:0] src1_tag,
    output logic                     src1_rdy,
    output logic [$clog2(DEPTH)-1:0] src2_tag,
    output logic                     src2_rdy,
    input  logic                     cmp_valid,
    input  logic [$clog2(DEPTH)-1:0] cmp_tag,
    input  logic [DATA_W-1:0]        cmp_data,
    input  logic                     cmp_exc,
    input  logic [CAUSE_W-1:0]       cmp_cause,
    output logic                     cm_valid,
    output logic [$clog2(DEPTH)-1:0] cm_tag,
    output logic [$clog2(NREG)-1:0]  cm_dst,
    output logic [DATA_W-1:0]        cm_data,
    output logic                     exc_valid,
    output logic [$clog2(DEPTH)-1:0] exc_tag,
    output logic [CAUSE_W-1:0]       exc_cause,
    input  logic                     flush,
    output logic                     empty,
    output logic                     full,
    input  logic [$clog2(DEPTH)-1:0] rd_tag,
    output logic                     rd_use,
    output logic                     rd_exec,
    output logic [OP_W-1:0]          rd_op,
    output logic [$clog2(DEPTH)-1:0] rd_src1_tag,
    output logic                     rd_src1_rdy,
    output logic [$clog2(DEPTH)-1:0] rd_src2_tag,
    output logic                     rd_src2_rdy
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int REG_W = $clog2(NREG);

    logic [TAG_W-1:0]   head_idx;
    logic [TAG_W-1:0]   tail_idx;
    logic [TAG_W:0]     occ;
    logic [DEPTH-1:0]   use_vec;
    logic [DEPTH-1:0]   exec_vec;
    logic               hd_exc;
    logic [CAUSE_W-1:0] hd_cause;
    logic [REG_W-1:0]   hd_dst;
    logic [DATA_W-1:0]  hd_data;
    logic [TAG_W-1:0]   q1_tag, q2_tag;
    logic               q1_hit, q2_hit;
    logic               cmp_hit;
    logic               push, pop, do_flush;
    head_act_e          act;

    // Decide what the oldest slot does this cycle.
    always_comb begin
        if (use_vec[head_idx] && exec_vec[head_idx])
            act = hd_exc ? HEAD_TRAP : HEAD_RETIRE;
        else
            act = HEAD_WAIT;
    end

    // Combine retirement, exception, flush and allocation controls.
    always_comb begin
        cmp_hit     = cmp_valid && use_vec[cmp_tag];
        cm_valid    = (act == HEAD_RETIRE) && !flush;
        exc_valid   = (act == HEAD_TRAP) && !flush;
        do_flush    = flush || (act == HEAD_TRAP);
        alloc_ready = !full && !do_flush;
        push        = alloc_valid && alloc_ready;
        pop         = cm_valid;
        alloc_tag   = tail_idx;
        cm_tag      = head_idx;
        cm_dst      = hd_dst;
        cm_data     = hd_data;
        exc_tag     = head_idx;
        exc_cause   = hd_cause;
        rd_use      = use_vec[rd_tag];
        rd_exec     = exec_vec[rd_tag];
    end

    // Source operands are available from retired state, a completed slot,
    // or a completion arriving this cycle.
    always_comb begin
        src1_tag = q1_tag;
        src2_tag = q2_tag;
        src1_rdy = !q1_hit || exec_vec[q1_tag] || (cmp_hit && cmp_tag == q1_tag);
        src2_rdy = !q2_hit || exec_vec[q2_tag] || (cmp_hit && cmp_tag == q2_tag);
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (do_flush),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .count    (occ),
        .full     (full),
        .empty    (empty)
    );

    rob_rename #(.NREG(NREG), .DEPTH(DEPTH)) u_rename (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (do_flush),
        .set_en  (push),
        .set_reg (alloc_dst),
        .set_tag (tail_idx),
        .clr_en  (pop),
        .clr_reg (hd_dst),
        .clr_tag (head_idx),
        .q1_reg  (alloc_src1),
        .q2_reg  (alloc_src2),
        .q1_tag  (q1_tag),
        .q1_hit  (q1_hit),
        .q2_tag  (q2_tag),
        .q2_hit  (q2_hit)
    );

    rob_entries #(
        .DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .OP_W(OP_W), .CAUSE_W(CAUSE_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (do_flush),
        .wr_en     (push),
        .wr_idx    (tail_idx),
        .wr_op     (alloc_op),
        .wr_dst    (alloc_dst),
        .wr_s1_tag (q1_tag),
        .wr_s1_rdy (src1_rdy),
        .wr_s2_tag (q2_tag),
        .wr_s2_rdy (src2_rdy),
        .cmp_valid (cmp_valid),
        .cmp_tag   (cmp_tag),
        .cmp_data  (cmp_data),
        .cmp_exc   (cmp_exc),
        .cmp_cause (cmp_cause),
        .ret_en    (pop),
        .ret_idx   (head_idx),
        .use_vec   (use_vec),
        .exec_vec  (exec_vec),
        .hd_idx    (head_idx),
        .hd_exc    (hd_exc),
        .hd_cause  (hd_cause),
        .hd_dst    (hd_dst),
        .hd_data   (hd_data),
        .rd_idx    (rd_tag),
        .rd_op     (rd_op),
        .rd_s1_tag (rd_src1_tag),
        .rd_s1_rdy (rd_src1_rdy),
        .rd_s2_tag (rd_src2_tag),
        .rd_s2_rdy (rd_src2_rdy)
    );

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_valid, exc_valid}));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> empty);

    // R2
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(use_vec) == int'(occ));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !do_flush) |=> $stable(alloc_tag));
endmodule

// File: tb/rob_rename_top_test.sv
// Directed and swept bench for the reorder buffer on a 4-slot,
// 4-register configuration.
module rob_rename_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH   = 4;
    localparam int NREG    = 4;
    localparam int DATA_W  = 8;
    localparam int OP_W    = 3;
    localparam int CAUSE_W = 3;
    localparam int TAG_W   = $clog2(DEPTH);
    localparam int REG_W   = $clog2(NREG);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               alloc_valid = 1'b0;
    logic [OP_W-1:0]    alloc_op = '0;
    logic [REG_W-1:0]   alloc_dst = '0, alloc_src1 = '0, alloc_src2 = '0;
    logic               alloc_ready;
    logic [TAG_W-1:0]   alloc_tag, src1_tag, src2_tag;
    logic               src1_rdy, src2_rdy;
    logic               cmp_valid = 1'b0;
    logic [TAG_W-1:0]   cmp_tag = '0;
    logic [DATA_W-1:0]  cmp_data = '0;
    logic               cmp_exc = 1'b0;
    logic [CAUSE_W-1:0] cmp_cause = '0;
    logic               cm_valid;
    logic [TAG_W-1:0]   cm_tag;
    logic [REG_W-1:0]   cm_dst;
    logic [DATA_W-1:0]  cm_data;
    logic               exc_valid;
    logic [TAG_W-1:0]   exc_tag;
    logic [CAUSE_W-1:0] exc_cause;
    logic               flush = 1'b0;
    logic               empty, full;
    logic [TAG_W-1:0]   rd_tag = '0;
    logic               rd_use, rd_exec;
    logic [OP_W-1:0]    rd_op;
    logic [TAG_W-1:0]   rd_src1_tag, rd_src2_tag;
    logic               rd_src1_rdy, rd_src2_rdy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rob_rename_top #(
        .DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .OP_W(OP_W), .CAUSE_W(CAUSE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_src1(alloc_src1), .alloc_src2(alloc_src2),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .src1_tag(src1_tag), .src1_rdy(src1_rdy), .src2_tag(src2_tag), .src2_rdy(src2_rdy),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .cmp_exc(cmp_exc), .cmp_cause(cmp_cause),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_dst(cm_dst), .cm_data(cm_data),
        .exc_valid(exc_valid), .exc_tag(exc_tag), .exc_cause(exc_cause),
        .flush(flush), .empty(empty), .full(full),
        .rd_tag(rd_tag), .rd_use(rd_use), .rd_exec(rd_exec), .rd_op(rd_op),
        .rd_src1_tag(rd_src1_tag), .rd_src1_rdy(rd_src1_rdy),
        .rd_src2_tag(rd_src2_tag), .rd_src2_rdy(rd_src2_rdy)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Wait one edge and settle away from it.
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic quiet();
        alloc_valid = 1'b0;
        cmp_valid   = 1'b0;
        cmp_exc     = 1'b0;
        flush       = 1'b0;
    endtask

    task automatic do_alloc(input int op, input int dst, input int s1, input int s2);
        alloc_valid = 1'b1;
        alloc_op    = OP_W'(op);
        alloc_dst   = REG_W'(dst);
        alloc_src1  = REG_W'(s1);
        alloc_src2  = REG_W'(s2);
    endtask

    task automatic do_cmp(input int tag, input int data, input bit exc, input int cause);
        cmp_valid = 1'b1;
        cmp_tag   = TAG_W'(tag);
        cmp_data  = DATA_W'(data);
        cmp_exc   = exc;
        cmp_cause = CAUSE_W'(cause);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bhead;
        int seq;
        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 alloc_ready", int'(alloc_ready), 1);
        check("R1 cm_valid", int'(cm_valid), 0);
        check("R1 exc_valid", int'(exc_valid), 0);
        check("R1 src1_rdy", int'(src1_rdy), 1);
        check("R1 src2_rdy", int'(src2_rdy), 1);

        // R2 fill the buffer; R6 chain lookups
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(i + 1, i, (i > 0) ? i - 1 : 0, 0);
            #1;
            check("R2 alloc tag", int'(alloc_tag), i);
            if (i > 0) begin
                check("R6 src tag", int'(src1_tag), i - 1);
                check("R6 src pending", int'(src1_rdy), 0);
            end
            cyc();
        end
        quiet();
        #1;
        // R3 full refuses allocation
        check("R3 full", int'(full), 1);
        check("R3 alloc_ready", int'(alloc_ready), 0);
        do_alloc(7, 0, 0, 0);
        cyc();
        quiet();
        rd_tag = 2'd0;
        #1;
        check("R3 slot untouched", int'(rd_op), 1);
        check("R3 still full", int'(full), 1);
        rd_tag = 2'd3;
        #1;
        check("R10 src1 tag", int'(rd_src1_tag), 2);
        check("R10 src1 not ready", int'(rd_src1_rdy), 0);
        check("R10 op", int'(rd_op), 4);

        // R4 out-of-order completion, R5 no early retire
        do_cmp(2, 8'h22, 1'b0, 0);
        cyc();
        quiet();
        #1;
        check("R5 wait for head", int'(cm_valid), 0);
        check("R10 wakeup", int'(rd_src1_rdy), 1);
        check("R4 recorded", int'(rd_exec), 0);
        rd_tag = 2'd2;
        #1;
        check("R4 recorded", int'(rd_exec), 1);
        do_cmp(1, 8'h21, 1'b0, 0);
        cyc();
        do_cmp(3, 8'h23, 1'b0, 0);
        alloc_src1 = 2'd3;
        #1;
        check("R6 bypass ready", int'(src1_rdy), 1);
        cyc();
        quiet();
        #1;
        check("R5 wait for head", int'(cm_valid), 0);
        do_cmp(0, 8'h20, 1'b0, 0);
        cyc();
        quiet();
        #1;
        for (int i = 0; i < DEPTH; i++) begin
            check("R5 cm_valid", int'(cm_valid), 1);
            check("R5 cm_tag", int'(cm_tag), i);
            check("R5 cm_dst", int'(cm_dst), i);
            check("R5 cm_data", int'(cm_data), 32 + i);
            cyc();
            #1;
        end
        check("R5 drained", int'(empty), 1);
        alloc_src1 = 2'd3;
        #1;
        check("R7 retired reg ready", int'(src1_rdy), 1);

        // R4 completion to a slot not in use
        do_cmp(1, 8'h77, 1'b1, 3);
        cyc();
        quiet();
        rd_tag = 2'd1;
        #1;
        check("R4 stray ignored exec", int'(rd_exec), 0);
        check("R4 stray ignored use", int'(rd_use), 0);
        check("R4 stray no outcome", int'(cm_valid | exc_valid), 0);

        // R7 younger mapping survives older retirement
        do_alloc(1, 2, 0, 0);
        #1;
        check("R2 wrap tag", int'(alloc_tag), 0);
        cyc();
        do_alloc(2, 2, 2, 0);
        #1;
        check("R6 newest tag", int'(src1_tag), 0);
        cyc();
        quiet();
        alloc_src1 = 2'd2;
        do_cmp(0, 8'h55, 1'b0, 0);
        #1;
        check("R6 newest tag", int'(src1_tag), 1);
        cyc();
        quiet();
        #1;
        check("R5 retire older", int'(cm_valid), 1);
        check("R5 retire older data", int'(cm_data), 8'h55);
        cyc();
        #1;
        check("R7 younger kept tag", int'(src1_tag), 1);
        check("R7 younger still pending", int'(src1_rdy), 0);
        do_cmp(1, 8'h66, 1'b0, 0);
        cyc();
        quiet();
        #1;
        check("R5 retire younger", int'(cm_tag), 1);
        cyc();
        #1;
        check("R7 cleared after match", int'(src1_rdy), 1);

        // R8 exception at the oldest slot (head now 2)
        do_alloc(3, 1, 0, 0);
        #1;
        check("R2 tag", int'(alloc_tag), 2);
        cyc();
        do_alloc(4, 3, 1, 0);
        #1;
        check("R6 src tag", int'(src1_tag), 2);
        cyc();
        quiet();
        do_cmp(3, 9, 1'b0, 0);
        cyc();
        do_cmp(2, 0, 1'b1, 5);
        cyc();
        quiet();
        #1;
        check("R8 exc_valid", int'(exc_valid), 1);
        check("R8 exc_tag", int'(exc_tag), 2);
        check("R8 exc_cause", int'(exc_cause), 5);
        check("R8 no retire", int'(cm_valid), 0);
        check("R8 alloc refused", int'(alloc_ready), 0);
        cyc();
        alloc_src1 = 2'd1;
        alloc_src2 = 2'd3;
        #1;
        check("R8 empty", int'(empty), 1);
        check("R8 next tag", int'(alloc_tag), 2);
        check("R8 table cleared r1", int'(src1_rdy), 1);
        check("R8 table cleared r3", int'(src2_rdy), 1);

        // R9 external flush
        do_alloc(1, 0, 0, 0);
        cyc();
        do_alloc(2, 1, 0, 0);
        cyc();
        quiet();
        do_cmp(2, 8'h11, 1'b0, 0);
        cyc();
        quiet();
        #1;
        check("R5 ready to retire", int'(cm_valid), 1);
        flush = 1'b1;
        #1;
        check("R9 retire suppressed", int'(cm_valid), 0);
        check("R9 no exception", int'(exc_valid), 0);
        cyc();
        quiet();
        alloc_src1 = 2'd0;
        alloc_src2 = 2'd1;
        #1;
        check("R9 empty", int'(empty), 1);
        check("R9 head kept", int'(alloc_tag), 2);
        check("R9 table cleared r0", int'(src1_rdy), 1);
        check("R9 table cleared r1", int'(src2_rdy), 1);

        // R2 R5 sweep: bursts of 1..DEPTH, reverse-order completion
        bhead = 2;
        seq = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            for (int r = 0; r < 6; r++) begin
                for (int i = 0; i < k; i++) begin
                    do_alloc(i, (seq + i) % NREG, 0, 0);
                    #1;
                    check("R2 sweep tag", int'(alloc_tag), (bhead + i) % DEPTH);
                    cyc();
                end
                quiet();
                for (int i = k - 1; i >= 0; i--) begin
                    do_cmp((bhead + i) % DEPTH, ((seq + i) * 7 + 3) % 256, 1'b0, 0);
                    #1;
                    check("R5 sweep hold", int'(cm_valid), 0);
                    cyc();
                end
                quiet();
                #1;
                for (int i = 0; i < k; i++) begin
                    check("R5 sweep valid", int'(cm_valid), 1);
                    check("R5 sweep tag", int'(cm_tag), (bhead + i) % DEPTH);
                    check("R5 sweep dst", int'(cm_dst), (seq + i) % NREG);
                    check("R5 sweep data", int'(cm_data), ((seq + i) * 7 + 3) % 256);
                    cyc();
                    #1;
                end
                check("R5 sweep empty", int'(empty), 1);
                bhead = (bhead + k) % DEPTH;
                seq = seq + k;
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule